// File: doc/BRIEF.md
# Carry-Increment Adder

A purely combinational adder of parameterized width that sums two operands and a carry input, producing a sum word and a carry output. The operand bits are split into groups. Each group resolves its internal carries as though no carry entered it. The group's actual incoming carry arrives later and is applied as an increment through that group's running prefix generate and propagate terms.

Per-bit generate and propagate are formed once for the whole word. A single shared XOR stage forms the sum. There is no second precomputed "carry-in = 1" copy as there would be in a carry-select structure. The group carry passes from group to group along a short chain.

Group sizing is chosen at elaboration time. Either every group has the same size, which defaults to 4 bits, or each successive group is one bit wider than the one before it. In both schemes the most significant group is truncated when the width does not divide evenly.

Top module: `cia_adder`

## Requirements
- R1: `{cout, sum}` equals `a + b + cin` taken at WIDTH+1 bits, for every operand pair and carry input.
- R2: For fixed operands, the `{cout, sum}` result with `cin = 1` is exactly one greater, modulo 2^(WIDTH+1), than the result with `cin = 0`.
- R3: The carry passed out of each group equals bit LO of `a[LO-1:0] + b[LO-1:0] + cin`, where LO is the lowest bit index of the next group.
- R4: When every bit position propagates (`a ^ b` all ones), `cout` equals `cin` and `sum` is all ones when `cin = 0` and all zeros when `cin = 1`. This covers all-ones plus one and alternating 0101/1010 operands.
- R5: When both operands have the most significant bit set, `cout` is 1.
- R6: With growing groups selected (`GROW = 1`, group k holds GRP+k bits), the results still satisfy R1.
- R7: When WIDTH is not a multiple of the group size, the last group is shorter and the results still satisfy R1.
- R8: With both operands zero, `sum` equals `cin` zero-extended and `cout` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | WIDTH | First operand |
| b | input | WIDTH | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | WIDTH | Sum word |
| cout | output | 1 | Carry out of the most significant bit |

## Verification
The checks assume the operands and carry input are fully known (no X or Z) and settled whenever they are evaluated. The checker skips any evaluation with unknown inputs. The bench changes the inputs only between samples and waits a settling step before reading the outputs. The group-carry check also assumes that group boundaries follow the package's sizing rule. The bench therefore exercises only parameter sets that rule supports: uniform groups, growing groups, and a width that is not a multiple of the group size.

// File: rtl/cia_pkg.sv
package cia_pkg;

  // Unclipped size of group k.
  function automatic int raw_size(int k, int base, int grow);
    return (grow != 0) ? base + k : base;
  endfunction

  // Lowest bit index of group k (clipped to width).
  function automatic int grp_lo(int k, int width, int base, int grow);
    int lo;
    lo = 0;
    for (int i = 0; i < k; i++) begin
      lo += raw_size(i, base, grow);
      if (lo > width) lo = width;
    end
    return lo;
  endfunction

  // Size of group k after truncation at the top of the word.
  function automatic int grp_size(int k, int width, int base, int grow);
    int lo;
    int sz;
    lo = grp_lo(k, width, base, grow);
    sz = raw_size(k, base, grow);
    if (lo >= width) sz = 0;
    else if (lo + sz > width) sz = width - lo;
    return sz;
  endfunction

  function automatic int num_grps(int width, int base, int grow);
    int n;
    n = 0;
    for (int i = 0; i < width; i++)
      if (grp_lo(i, width, base, grow) < width) n++;
    return n;
  endfunction

endpackage

// File: rtl/cia_pg_bits.sv
module cia_pg_bits #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [WIDTH-1:0] gen,
  output logic [WIDTH-1:0] prop
);
  always_comb begin
    gen  = a & b;
    prop = a ^ b;
  end
endmodule

// File: rtl/cia_group.sv
module cia_group #(
  parameter int SZ = 4
) (
  input  logic [SZ-1:0] gen,
  input  logic [SZ-1:0] prop,
  input  logic          cg,
  output logic [SZ-1:0] cbit,
  output logic          cnext
);
  // Prefix terms assuming no group carry-in.
  logic [SZ-1:0] pre_g;
  logic [SZ-1:0] pre_p;

  assign pre_g[0] = gen[0];
  assign pre_p[0] = prop[0];
  assign cbit[0]  = cg;

  for (genvar i = 1; i < SZ; i++) begin : g_pre
    assign pre_g[i] = gen[i] | (prop[i] & pre_g[i-1]);
    assign pre_p[i] = prop[i] & pre_p[i-1];
    // Increment step: fold the late group carry into the prefix result.
    assign cbit[i]  = pre_g[i-1] | (pre_p[i-1] & cg);
  end

  assign cnext = pre_g[SZ-1] | (pre_p[SZ-1] & cg);
endmodule

// File: rtl/cia_sum_xor.sv
module cia_sum_xor #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] prop,
  input  logic [WIDTH-1:0] cbit,
  output logic [WIDTH-1:0] sum
);
  assign sum = prop ^ cbit;
endmodule

// File: rtl/cia_adder.sv
module cia_adder #(
  parameter int WIDTH = 32,
  parameter int GRP   = 4,
  parameter int GROW  = 0
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout
);
  import cia_pkg::*;

  localparam int NGRP = num_grps(WIDTH, GRP, GROW);

  logic [WIDTH-1:0] gen;
  logic [WIDTH-1:0] prop;
  logic [WIDTH-1:0] cbit;
  logic [NGRP:0]    gcarry;

  cia_pg_bits #(.WIDTH(WIDTH)) u_pg (
    .a(a), .b(b), .gen(gen), .prop(prop)
  );

  assign gcarry[0] = cin;

  for (genvar k = 0; k < NGRP; k++) begin : g_grp
    localparam int LO = grp_lo(k, WIDTH, GRP, GROW);
    localparam int SZ = grp_size(k, WIDTH, GRP, GROW);
    cia_group #(.SZ(SZ)) u_grp (
      .gen  (gen[LO+SZ-1:LO]),
      .prop (prop[LO+SZ-1:LO]),
      .cg   (gcarry[k]),
      .cbit (cbit[LO+SZ-1:LO]),
      .cnext(gcarry[k+1])
    );
  end

  cia_sum_xor #(.WIDTH(WIDTH)) u_sum (
    .prop(prop), .cbit(cbit), .sum(sum)
  );

  assign cout = gcarry[NGRP];
endmodule

// File: rtl/cia_adder_chk.sv
module cia_adder_chk #(
  parameter int WIDTH = 32,
  parameter int GRP   = 4,
  parameter int GROW  = 0,
  parameter int NGRP  = 8
) (
  input logic [WIDTH-1:0] a,
  input logic [WIDTH-1:0] b,
  input logic             cin,
  input logic [WIDTH-1:0] sum,
  input logic             cout,
  input logic [NGRP:0]    gcarry
);
  import cia_pkg::*;

  logic             known;
  logic [WIDTH:0]   full;
  assign known = !$isunknown({a, b, cin});
  assign full  = {1'b0, a} + {1'b0, b} + (WIDTH+1)'(cin);

  always_comb begin
    if (known) begin
      p_sum_exact_r1: assert ({cout, sum} == full)
        else $error("R1 sum mismatch");
      p_all_prop_r4: assert (!(&(a ^ b)) || (cout == cin && sum == {WIDTH{!cin}}))
        else $error("R4 propagate chain");
      p_msb_gen_r5: assert (!(a[WIDTH-1] && b[WIDTH-1]) || cout)
        else $error("R5 msb generate");
      p_zero_ops_r8: assert (!(a == '0 && b == '0) || ({cout, sum} == (WIDTH+1)'(cin)))
        else $error("R8 zero operands");
    end
  end

  for (genvar k = 1; k <= NGRP; k++) begin : g_gc
    localparam int LO = grp_lo(k, WIDTH, GRP, GROW);
    localparam logic [WIDTH-1:0] MASK = {WIDTH{1'b1}} >> (WIDTH - LO);
    logic [WIDTH:0] low_sum;
    assign low_sum = {1'b0, a & MASK} + {1'b0, b & MASK} + (WIDTH+1)'(cin);
    always_comb begin
      if (known) begin
        p_grp_carry_r3: assert (gcarry[k] == low_sum[LO])
          else $error("R3 group carry %0d", k);
      end
    end
  end
endmodule

bind cia_adder cia_adder_chk #(
  .WIDTH(WIDTH), .GRP(GRP), .GROW(GROW), .NGRP(NGRP)
) u_chk (
  .a(a), .b(b), .cin(cin), .sum(sum), .cout(cout), .gcarry(gcarry)
);

// File: tb/cia_adder_test.sv
`timescale 1ns/1ps
module cia_adder_test;
  logic clk;
  int   n_chk;
  int   n_err;
  int   cyc;
  bit   done;

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // 8-bit uniform groups: exhaustive.
  logic [7:0]  a8, b8, s8;
  logic        c8, co8;
  // 16-bit growing groups (2,3,4,5,2).
  logic [15:0] a16, b16, s16;
  logic        c16, co16;
  // 10-bit, groups of 4 (last group 2 bits).
  logic [9:0]  a10, b10, s10;
  logic        c10, co10;
  // 32-bit default configuration.
  logic [31:0] a32, b32, s32;
  logic        c32, co32;

  cia_adder #(.WIDTH(8), .GRP(4), .GROW(0)) uut (
    .a(a8), .b(b8), .cin(c8), .sum(s8), .cout(co8));
  cia_adder #(.WIDTH(16), .GRP(2), .GROW(1)) uut_grow (
    .a(a16), .b(b16), .cin(c16), .sum(s16), .cout(co16));
  cia_adder #(.WIDTH(10), .GRP(4), .GROW(0)) uut_odd (
    .a(a10), .b(b10), .cin(c10), .sum(s10), .cout(co10));
  cia_adder uut_wide (
    .a(a32), .b(b32), .cin(c32), .sum(s32), .cout(co32));

  task automatic chk(input string tag, input logic [32:0] got, input logic [32:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  task automatic run32(input logic [31:0] x, input logic [31:0] y, input logic ci, input string tag);
    a32 = x; b32 = y; c32 = ci;
    #1;
    chk(tag, {co32, s32}, {1'b0, x} + {1'b0, y} + 33'(ci));
  endtask

  initial begin
    logic [8:0] r0;
    n_chk = 0; n_err = 0; cyc = 0; done = 1'b0;
    a8 = '0; b8 = '0; c8 = 1'b0;
    a16 = '0; b16 = '0; c16 = 1'b0;
    a10 = '0; b10 = '0; c10 = 1'b0;
    a32 = '0; b32 = '0; c32 = 1'b0;
    #1;
    // R8: zero operands at start.
    chk("R8 zero cin0", {24'd0, co8, s8}, 33'd0);
    c8 = 1'b1; #1;
    chk("R8 zero cin1", {24'd0, co8, s8}, 33'd1);

    // R1/R2: exhaustive 8-bit sweep.
    for (int i = 0; i < 256; i++) begin
      for (int j = 0; j < 256; j++) begin
        a8 = 8'(i); b8 = 8'(j); c8 = 1'b0; #1;
        r0 = {co8, s8};
        chk("R1 cin0", {24'd0, co8, s8}, 33'(i + j));
        c8 = 1'b1; #1;
        chk("R1 cin1", {24'd0, co8, s8}, 33'(i + j + 1));
        chk("R2 increment", {24'd0, co8, s8}, {24'd0, 9'(r0 + 9'd1)});
      end
    end

    // R6: growing groups, random plus corners.
    for (int i = 0; i < 3000; i++) begin
      a16 = 16'($urandom); b16 = 16'($urandom); c16 = 1'($urandom);
      if (i == 0) begin a16 = 16'hFFFF; b16 = 16'h0000; c16 = 1'b1; end
      if (i == 1) begin a16 = 16'h5555; b16 = 16'hAAAA; c16 = 1'b1; end
      #1;
      chk("R6 grow", {16'd0, co16, s16}, {16'd0, 17'({1'b0, a16} + {1'b0, b16} + 17'(c16))});
    end

    // R7: width not a multiple of group size.
    for (int i = 0; i < 3000; i++) begin
      a10 = 10'($urandom); b10 = 10'($urandom); c10 = 1'($urandom);
      if (i == 0) begin a10 = 10'h3FF; b10 = 10'h000; c10 = 1'b1; end
      #1;
      chk("R7 odd width", {22'd0, co10, s10}, {22'd0, 11'({1'b0, a10} + {1'b0, b10} + 11'(c10))});
    end

    // R4: full propagate chains on the default width.
    run32(32'hFFFF_FFFF, 32'h0000_0000, 1'b1, "R4 all-ones plus one");
    chk("R4 all-ones cout", {32'd0, co32}, 33'd1);
    run32(32'h5555_5555, 32'hAAAA_AAAA, 1'b0, "R4 alternating cin0");
    chk("R4 alt sum ones", {1'b0, s32}, {1'b0, 32'hFFFF_FFFF});
    run32(32'hAAAA_AAAA, 32'h5555_5555, 1'b1, "R4 alternating cin1");
    chk("R4 alt sum zero", {co32, s32}, {1'b1, 32'h0});
    // R5: both MSBs set.
    run32(32'h8000_0000, 32'h8000_0000, 1'b0, "R5 msb gen");
    chk("R5 cout", {32'd0, co32}, 33'd1);
    run32(32'hC000_1234, 32'h9FFF_0001, 1'b1, "R5 msb gen mixed");
    // R8 on default width.
    run32(32'h0, 32'h0, 1'b1, "R8 zero wide");
    // R1: random on default width, plus group-boundary carries (R3).
    run32(32'h0000_000F, 32'h0000_0001, 1'b0, "R3 boundary carry");
    run32(32'h0FFF_FFFF, 32'h0000_0000, 1'b1, "R3 long ripple");
    for (int i = 0; i < 5000; i++)
      run32($urandom, $urandom, 1'($urandom), "R1 wide random");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule